// File: doc/BRIEF.md
# Control-Flow Trace Unit

The unit watches the instructions a processor core retires and turns the control-flow transfers among them into compact trace records. A jump-and-link that writes the return-address register is logged as a call, and the record carries the jump target. An indirect jump through the return-address register that links nothing is logged as a return, and the record carries the address it returns to. Separately, any change of the core's 2-bit privilege level produces a record that carries the new level. Every record is stamped with the value of a free-running cycle counter taken in the cycle of capture.

Records wait in a four-entry queue and leave over a valid/ready stream. If the queue cannot take an event, the event is dropped and a saturating miss counter is incremented. When a slot frees up, a single overflow record carrying that count is queued ahead of any newer event, and the counter then starts again from zero. Capture is gated by a level enable input that stays low until configuration sets it. Records already in the queue, and a pending overflow record, still drain while capture is off.

Top module: `ctrace_unit`

## Requirements
- R1: After reset the stream output is idle (evValid low), the miss count is zero and the timestamp counter restarts from 0 on the first clock edge after reset is released.
- R2: While captureEn is low, no call, return or mode record is queued and no miss is counted. The privilege level is still tracked, so a level change made while capture is off produces no record once capture is turned on.
- R3: A retired instruction with retJal or retJalr set and retRd equal to 1 queues a record of type 0 (call) whose data field is retTarget.
- R4: A retired instruction with retJalr set, retRs1 equal to 1 and retRd equal to 0 queues a record of type 1 (return) whose data field is retTarget. A jump-and-link whose retRd is 0 and an indirect jump through any other register produce no record.
- R5: A change of privMode from its value in the previous cycle queues a record of type 2 whose data field is the new level, zero-extended.
- R6: evTime of every record equals the number of rising clock edges between the release of reset and the edge at which the record was captured.
- R7: When a mode change and a call or return are captured in the same cycle, the mode record is queued ahead of the call or return record.
- R8: Records leave in capture order, one per cycle with evValid and evReady both high. While evValid is high and evReady is low, the record on the outputs holds steady. The queue holds 4 records. Free space is judged on the occupancy before that cycle's pop.
- R9: An event that finds no free slot is dropped and counted. When the count is nonzero and a slot is free, a record of type 3 whose data field is the count is queued before any event of the same cycle, and the count restarts from that cycle's own drops.
- R10: The miss count is 16 bits wide and saturates at 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| captureEn | input | 1 | Capture enable level, held by configuration |
| retValid | input | 1 | An instruction retires this cycle |
| retJal | input | 1 | Retired instruction is a direct jump-and-link |
| retJalr | input | 1 | Retired instruction is an indirect jump-and-link |
| retRd | input | 5 | Destination (link) register index |
| retRs1 | input | 5 | Base register index of an indirect jump |
| retTarget | input | 32 | Address control transfers to |
| privMode | input | 2 | Current privilege level of the core |
| evValid | output | 1 | Record available |
| evReady | input | 1 | Consumer takes the record |
| evType | output | 2 | 0 call, 1 return, 2 mode change, 3 overflow |
| evTime | output | 32 | Capture timestamp |
| evData | output | 32 | Target, return address, new level or miss count |

## Verification
The assertions check on every cycle that a stalled record stays unchanged, that nothing new appears while capture is off and no miss is pending, that overflow records never carry a zero count, that mode records carry only a 2-bit value, and that a saturated miss count stays saturated until it is emitted. Whether calls and returns are told apart correctly, whether the ordering inside one cycle is right, whether timestamps are exact and whether the drop counts add up can only be shown by the bench's scenarios. Those scenarios include a stall long enough to saturate the counter, a same-cycle mode change with a call, and mixed random traffic compared against a reference queue.

// File: rtl/ctrace_pkg.sv
package ctrace_pkg;

  typedef enum logic [1:0] {
    EV_CALL = 2'd0,
    EV_RET  = 2'd1,
    EV_MODE = 2'd2,
    EV_OVF  = 2'd3
  } ctrace_kind_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic pushOvf;
    logic pushMode;
    logic pushFlow;
    logic flowIsRet;
    logic pop;
  } ctrace_strobe_t;

endpackage

// File: rtl/ctrace_ctrl.sv
module ctrace_ctrl
  import ctrace_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int MISS_W = 16,
  parameter int REG_W  = 5,
  parameter int RA_IDX = 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureEn,
  input  logic              retValid,
  input  logic              retJal,
  input  logic              retJalr,
  input  logic [REG_W-1:0]  retRd,
  input  logic [REG_W-1:0]  retRs1,
  input  logic [1:0]        privMode,
  input  logic              evReady,
  input  logic [CNT_W-1:0]  qCount,
  output ctrace_strobe_t    strb,
  output logic [MISS_W-1:0] missCount
);

  localparam logic [REG_W-1:0] RA = REG_W'(RA_IDX);

  logic [1:0]       lastMode;
  logic             modeChange, isCall, isRet, flowEv, wantOvf;
  logic [CNT_W-1:0] freeSlots, leftAfterOvf, leftAfterMode;
  logic [1:0]       drops;
  logic [MISS_W-1:0] missBase;
  logic [MISS_W:0]  missSum;

  // event decode
  always_comb begin
    modeChange = captureEn && (privMode != lastMode);
    isCall     = retValid && (retJal || retJalr) && (retRd == RA);
    isRet      = retValid && retJalr && (retRs1 == RA) && (retRd == '0);
    flowEv     = captureEn && (isCall || isRet);
  end

  // slot allocation: overflow record, then mode, then call/return
  always_comb begin
    wantOvf       = (missCount != '0);
    freeSlots     = CNT_W'(DEPTH) - qCount;
    strb.pushOvf  = wantOvf && (freeSlots != '0);
    leftAfterOvf  = freeSlots - CNT_W'(strb.pushOvf);
    strb.pushMode = modeChange && (leftAfterOvf != '0);
    leftAfterMode = leftAfterOvf - CNT_W'(strb.pushMode);
    strb.pushFlow = flowEv && (leftAfterMode != '0);
    strb.flowIsRet = !isCall;
    strb.pop      = (qCount != '0) && evReady;
    drops         = 2'(modeChange && !strb.pushMode) + 2'(flowEv && !strb.pushFlow);
    missBase      = strb.pushOvf ? '0 : missCount;
    missSum       = {1'b0, missBase} + (MISS_W + 1)'(drops);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastMode  <= 2'd3;
      missCount <= '0;
    end else begin
      lastMode  <= privMode;
      missCount <= missSum[MISS_W] ? '1 : missSum[MISS_W-1:0];
    end
  end

endmodule

// File: rtl/ctrace_dpath.sv
module ctrace_dpath
  import ctrace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TS_W   = 32,
  parameter int DEPTH  = 4,
  parameter int MISS_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrace_strobe_t    strb,
  input  logic [1:0]        privMode,
  input  logic [ADDR_W-1:0] retTarget,
  input  logic [MISS_W-1:0] missCount,
  output logic [CNT_W-1:0]  qCount,
  output logic              evValid,
  output logic [1:0]        evType,
  output logic [TS_W-1:0]   evTime,
  output logic [ADDR_W-1:0] evData
);

  // DEPTH is a power of two so the pointers wrap naturally
  localparam int PTR_W = $clog2(DEPTH);
  localparam int REC_W = 2 + TS_W + ADDR_W;

  logic [TS_W-1:0]  timeNow;
  logic [PTR_W-1:0] head, tail, modeIdx, flowIdx;
  logic [REC_W-1:0] ovfRec, modeRec, flowRec, headRec;
  logic [REC_W-1:0] slotRec [DEPTH];
  ctrace_kind_e     flowKind;

  always_comb begin
    flowKind = strb.flowIsRet ? EV_RET : EV_CALL;
    ovfRec   = {EV_OVF, timeNow, ADDR_W'(missCount)};
    modeRec  = {EV_MODE, timeNow, ADDR_W'(privMode)};
    flowRec  = {flowKind, timeNow, retTarget};
    modeIdx  = tail + PTR_W'(strb.pushOvf);
    flowIdx  = modeIdx + PTR_W'(strb.pushMode);
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [REC_W-1:0] rec;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rec <= '0;
      end else if (strb.pushFlow && flowIdx == PTR_W'(s)) begin
        rec <= flowRec;
      end else if (strb.pushMode && modeIdx == PTR_W'(s)) begin
        rec <= modeRec;
      end else if (strb.pushOvf && tail == PTR_W'(s)) begin
        rec <= ovfRec;
      end
    end
    assign slotRec[s] = rec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeNow <= '0;
      head    <= '0;
      tail    <= '0;
      qCount  <= '0;
    end else begin
      timeNow <= timeNow + 1'b1;
      head    <= head + PTR_W'(strb.pop);
      tail    <= tail + PTR_W'(strb.pushOvf) + PTR_W'(strb.pushMode) + PTR_W'(strb.pushFlow);
      qCount  <= qCount + CNT_W'(strb.pushOvf) + CNT_W'(strb.pushMode)
               + CNT_W'(strb.pushFlow) - CNT_W'(strb.pop);
    end
  end

  always_comb begin
    headRec = slotRec[head];
    evValid = (qCount != '0);
    evType  = headRec[REC_W-1 -: 2];
    evTime  = headRec[ADDR_W +: TS_W];
    evData  = headRec[ADDR_W-1:0];
  end

endmodule

// File: rtl/ctrace_unit.sv
module ctrace_unit
  import ctrace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TS_W   = 32,
  parameter int DEPTH  = 4,
  parameter int MISS_W = 16,
  parameter int REG_W  = 5,
  parameter int RA_IDX = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureEn,
  input  logic              retValid,
  input  logic              retJal,
  input  logic              retJalr,
  input  logic [REG_W-1:0]  retRd,
  input  logic [REG_W-1:0]  retRs1,
  input  logic [ADDR_W-1:0] retTarget,
  input  logic [1:0]        privMode,
  output logic              evValid,
  input  logic              evReady,
  output logic [1:0]        evType,
  output logic [TS_W-1:0]   evTime,
  output logic [ADDR_W-1:0] evData
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  ctrace_strobe_t    strb;
  logic [CNT_W-1:0]  qCount;
  logic [MISS_W-1:0] missCount;

  ctrace_ctrl #(
    .DEPTH(DEPTH), .MISS_W(MISS_W), .REG_W(REG_W), .RA_IDX(RA_IDX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .captureEn(captureEn),
    .retValid(retValid), .retJal(retJal), .retJalr(retJalr),
    .retRd(retRd), .retRs1(retRs1), .privMode(privMode),
    .evReady(evReady), .qCount(qCount), .strb(strb), .missCount(missCount)
  );

  ctrace_dpath #(
    .ADDR_W(ADDR_W), .TS_W(TS_W), .DEPTH(DEPTH), .MISS_W(MISS_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .privMode(privMode),
    .retTarget(retTarget), .missCount(missCount), .qCount(qCount),
    .evValid(evValid), .evType(evType), .evTime(evTime), .evData(evData)
  );

endmodule

// File: rtl/ctrace_chk.sv
module ctrace_chk #(
  parameter int ADDR_W = 32,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              captureEn,
  input logic              evValid,
  input logic              evReady,
  input logic [1:0]        evType,
  input logic [ADDR_W-1:0] evData,
  input logic [MISS_W-1:0] missCount
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !evReady) |=> (evValid && $stable(evType) && $stable(evData)));

  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!captureEn && !evValid && missCount == '0) |=> !evValid);

  // R9
  ovf_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evType == 2'd3) |-> (evData != '0));

  // R5
  mode_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evType == 2'd2) |-> (evData[ADDR_W-1:2] == '0));

  // R10
  miss_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missCount == '1) |=> (missCount == '1 || missCount <= MISS_W'(2)));

endmodule

bind ctrace_unit ctrace_chk #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) u_chk (.*);

// File: tb/test_ctrace_unit.sv
`timescale 1ns/1ps
module test_ctrace_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        captureEn = 1'b0;
  logic        retValid = 1'b0, retJal = 1'b0, retJalr = 1'b0;
  logic [4:0]  retRd = '0, retRs1 = '0;
  logic [31:0] retTarget = '0;
  logic [1:0]  privMode = 2'd3;
  logic        evReady = 1'b0;
  logic        evValid;
  logic [1:0]  evType;
  logic [31:0] evTime, evData;

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference queue
  bit [1:0]  qT [8];
  bit [31:0] qTm [8];
  bit [31:0] qD [8];
  int mCount = 0, mMiss = 0;
  bit [1:0] mLast = 2'd3;
  bit [31:0] mTime = 0;

  always #2.5 clk = ~clk;

  ctrace_unit i_ctrace_unit (
    .clk(clk), .rstN(rstN), .captureEn(captureEn), .retValid(retValid),
    .retJal(retJal), .retJalr(retJalr), .retRd(retRd), .retRs1(retRs1),
    .retTarget(retTarget), .privMode(privMode), .evValid(evValid),
    .evReady(evReady), .evType(evType), .evTime(evTime), .evData(evData)
  );

  function automatic void push(bit [1:0] t, bit [31:0] d);
    qT[mCount] = t; qTm[mCount] = mTime; qD[mCount] = d; mCount++;
  endfunction

  // one clock edge of the required behaviour, using the driven inputs
  function automatic void modelStep();
    int  freeS = 4 - mCount;
    int  left;
    int  sum;
    bit  modeCh = captureEn && (privMode != mLast);
    bit  isCall = retValid && (retJal || retJalr) && retRd == 5'd1;
    bit  isRet  = retValid && retJalr && retRs1 == 5'd1 && retRd == 5'd0;
    bit  flowEv = captureEn && (isCall || isRet);
    bit  pOvf, pMode, pFlow;
    int  oldMiss = mMiss;
    pOvf  = (mMiss != 0) && freeS >= 1;
    left  = freeS - int'(pOvf);
    pMode = modeCh && left >= 1;
    left  = left - int'(pMode);
    pFlow = flowEv && left >= 1;
    sum = (pOvf ? 0 : mMiss) + int'(modeCh && !pMode) + int'(flowEv && !pFlow);
    mMiss = (sum > 65535) ? 65535 : sum;
    if (mCount > 0 && evReady) begin
      for (int i = 0; i < 7; i++) begin
        qT[i] = qT[i+1]; qTm[i] = qTm[i+1]; qD[i] = qD[i+1];
      end
      mCount--;
    end
    if (pOvf)  push(2'd3, 32'(oldMiss));
    if (pMode) push(2'd2, 32'(privMode));
    if (pFlow) push(isCall ? 2'd0 : 2'd1, retTarget);
    mLast = privMode;
    mTime++;
  endfunction

  function automatic string autoTag();
    if (mCount == 0) return "R8";
    case (qT[0])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(string tag);
    bit expV = (mCount != 0);
    bit bad;
    vectors++;
    bad = (evValid !== expV);
    if (expV && !bad)
      bad = (evType !== qT[0]) || (evTime !== qTm[0]) || (evData !== qD[0]);
    if (bad) begin
      errors++;
      $display("FAIL %s: got valid=%0b type=%0d time=%0d data=%0h, expected valid=%0b type=%0d time=%0d data=%0h",
               tag, evValid, evType, evTime, evData, expV, qT[0], qTm[0], qD[0]);
    end
  endtask

  task automatic step(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic setRet(bit v, bit jal, bit jalr, bit [4:0] rd, bit [4:0] rs1, bit [31:0] tgt);
    retValid = v; retJal = jal; retJalr = jalr; retRd = rd; retRs1 = rs1; retTarget = tgt;
  endtask

  task automatic idle();
    setRet(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    evReady = 1'b1;
    step("R1");

    // capture off: calls, returns and a level change leave no trace
    captureEn = 1'b0;
    setRet(1, 1, 0, 5'd1, 0, 32'h1000); step("R2");
    setRet(1, 0, 1, 5'd0, 5'd1, 32'h1004); privMode = 2'd1; step("R2");
    idle(); step("R2");
    captureEn = 1'b1; step("R2");        // level 1 already tracked
    privMode = 2'd3; step("R5");         // R5: change back to 3
    step("R5");

    // calls and returns
    setRet(1, 1, 0, 5'd1, 0, 32'h2000); step("R3");   // jal ra
    setRet(1, 0, 1, 5'd1, 5'd7, 32'h2100); step("R3"); // jalr ra
    setRet(1, 0, 1, 5'd0, 5'd1, 32'h2200); step("R4"); // ret
    setRet(1, 1, 0, 5'd0, 0, 32'h2300); step("R4");    // plain jump: nothing
    setRet(1, 0, 1, 5'd0, 5'd5, 32'h2400); step("R4"); // jr other reg: nothing
    idle(); step("R6"); step("R6");

    // same-cycle mode change and call
    privMode = 2'd1; setRet(1, 1, 0, 5'd1, 0, 32'h3000); step("R7");
    idle(); step("R7"); step("R7");

    // stall: four held, two dropped, then overflow record first
    evReady = 1'b0;
    for (int i = 0; i < 6; i++) begin
      setRet(1, 1, 0, 5'd1, 0, 32'h4000 + 32'(i) * 4); step("R8");
    end
    idle(); step("R8");
    evReady = 1'b1;
    for (int i = 0; i < 8; i++) step("R9");

    // saturation: two drops per cycle while stalled
    evReady = 1'b0;
    for (int i = 0; i < 33000; i++) begin
      privMode = (i % 2 == 0) ? 2'd2 : 2'd0;
      setRet(1, 1, 0, 5'd1, 0, 32'h5000); step("R10");
    end
    if (mMiss != 65535) begin
      errors++; $display("FAIL R10: reference count %0d expected 65535", mMiss);
    end
    idle(); evReady = 1'b1;
    for (int i = 0; i < 8; i++) step("R10");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      case (k)
        0, 1: setRet(1, 1, 0, 5'd1, 0, $urandom);
        2:    setRet(1, 0, 1, 5'd1, 5'($urandom_range(0, 31)), $urandom);
        3, 4: setRet(1, 0, 1, 5'd0, 5'd1, $urandom);
        5:    setRet(1, 1, 0, 5'd0, 0, $urandom);
        6:    setRet(1, 0, 1, 5'd0, 5'd9, $urandom);
        7:    setRet(0, 1, 0, 5'd1, 0, $urandom);
        default: idle();
      endcase
      if ($urandom_range(0, 5) == 0) privMode = 2'($urandom_range(0, 3));
      evReady = ($urandom_range(0, 9) < 6);
      if ($urandom_range(0, 99) == 0) captureEn = ~captureEn;
      modelStep();
      @(posedge clk);
      @(negedge clk);
      compare(autoTag());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no end, expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule